// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message-signalled interrupt state of one function: a table holding, for every vector, a 64-bit message address, a 32-bit message data word and a vector control word, plus a packed pending array with one bit per vector. Software reaches all three regions through a single register port that carries 32-bit and 64-bit accesses, selected by a space code. Device logic raises events on a request strobe with a vector number. Each event leaves the block as an address/data message on a valid/ready output, or is parked as a pending bit.

Masking has two layers. The control word carries a function-wide mask and an enable. Bit 0 of each vector control word masks that vector alone. An event goes out at once only when the function is enabled and unmasked and the vector is unmasked. Clearing a vector mask or the function mask releases whatever was pending behind it. Released vectors drain one message at a time, lowest vector number first, and their pending bits are cleared.

Top module: `msix_vector_ctl`

## Requirements
- R1: After reset, every entry reads address 0, data 0 and vector control 0x1. The control word reads 0x4000 (masked, disabled) with bits 10:0 equal to NUM_VEC-1. Every pending word reads 0.
- R2: Table entries are 16 bytes apart. With a 32-bit access, entry offset 0x0 is the low address, 0x4 the high address, 0x8 the message data and 0xC the vector control. Read data returns in the low 32 bits, upper bits zero, one cycle after the access (regRvalid).
- R3: A 64-bit table access at entry offset 0x0 carries {high address, low address}, and one at 0x8 carries {vector control, message data}, with the first-named field in bits 63:32.
- R4: Control word (space 0, offset 0): bit 15 is the enable and bit 14 the function mask, and both are writable. Bits 10:0 always read NUM_VEC-1, and bits 13:11 read zero.
- R5: An event on an enabled, unmasked function for an unmasked vector produces exactly one message with msgAddr = {high, low} and msgData = the entry's data. While msgReady is low, msgValid, msgAddr and msgData hold steady.
- R6: An event that is not sent at once sets pending bit (vec mod 64) of pending word (vec / 64) and produces no message. This covers a disabled function, a masked function and a masked vector.
- R7: A pending word is read as a 32-bit access at word offset 0x0 (bits 31:0) or 0x4 (bits 63:32), or as a 64-bit access at 0x0. Pending words are 8 bytes apart and number NUM_VEC/64+1. Writes to the pending space change nothing.
- R8: A vector control write that takes bit 0 from 1 to 0 while the function mask is clear sends that vector's message once if its pending bit is set, and clears that bit. With the function mask set, the bit stays pending and nothing is sent.
- R9: When a control write takes the function mask from 1 to 0, every unmasked vector with a pending bit is sent, one message each, in ascending vector order, and those bits are cleared. Masked vectors stay pending. A control write that leaves the mask clear sends nothing.
- R10: Any of the following reads as zero and, on a write, changes nothing: an unaligned offset, a size code other than 2 (4 bytes) or 3 (8 bytes), an entry or word index beyond the array, a nonzero control offset, or space code 3.
- R11: An event that arrives in the same cycle as the write unmasking its vector, or as the write clearing the function mask, is delivered exactly once and leaves no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSpace | input | 2 | 0 control, 1 table, 2 pending array, 3 unused |
| regAddr | input | ADDR_W | Byte offset inside the space |
| regSize | input | 2 | 2 = 4-byte, 3 = 8-byte access |
| regWdata | input | 64 | Write data, little-endian |
| regRvalid | output | 1 | Read data valid, one cycle after a read |
| regRdata | output | 64 | Read data |
| intReq | input | 1 | Interrupt event strobe |
| intVec | input | VW | Vector number of the event |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message accepted |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |

## Verification
Two collisions get direct tests: an event on the same clock as the table write that clears its vector mask, and an event on the same clock as the control write that clears the function mask. In both, the event first lands in the pending array and is then released in that same cycle. The bench drives both stimuli between the same pair of falling edges. It passes the case only if exactly one message with the vector's address and data appears and a later pending-array read shows that vector's bit clear. The same message monitor also checks the order of a multi-vector drain after a function unmask.

// File: rtl/msix_pkg.sv
package msix_pkg;

  localparam logic [1:0] SP_CTL = 2'd0;
  localparam logic [1:0] SP_TAB = 2'd1;
  localparam logic [1:0] SP_PBA = 2'd2;

  localparam logic [1:0] SZ_W32 = 2'd2;
  localparam logic [1:0] SZ_W64 = 2'd3;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic       wrLo;
    logic       wrHi;
    logic       wrDat;
    logic       wrVc;
    logic       wide;
    logic       rdEn;
    logic       rdTab;
    logic       rdPba;
    logic       rdCtl;
    logic [1:0] rdSel;
    logic       evPend;
    logic       evSend;
    logic       flushAll;
  } dpStrobe_t;

endpackage

// File: rtl/msix_ctrl.sv
module msix_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 16,
  localparam int VW        = $clog2(NUM_VEC),
  localparam int PBA_WORDS = NUM_VEC / 64 + 1,
  localparam int PW        = (PBA_WORDS > 1) ? $clog2(PBA_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regSpace,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regSize,
  input  logic [1:0]        ctlBits,
  input  logic              intReq,
  input  logic [VW-1:0]     intVec,
  input  logic [NUM_VEC-1:0] vecMask,
  output dpStrobe_t         stb,
  output logic [VW-1:0]     entryIdx,
  output logic [PW-1:0]     pbaIdx,
  output logic              funcMasked,
  output logic              funcEnabled
);

  logic              sz32, sz64;
  logic [ADDR_W-5:0] entryRaw;
  logic [ADDR_W-4:0] pbaRaw;
  logic [3:0]        sub;
  logic [1:0]        sel;
  logic              entryOk, pbaOk, tabHit, pbaHit, ctlHit, ctlWr;
  logic              fmaskQ, fenQ;
  logic              evInRange, deliver;

  assign sz32     = (regSize == SZ_W32);
  assign sz64     = (regSize == SZ_W64);
  assign entryRaw = regAddr[ADDR_W-1:4];
  assign pbaRaw   = regAddr[ADDR_W-1:3];
  assign sub      = regAddr[3:0];
  assign sel      = sub[3:2];
  assign entryOk  = (32'(entryRaw) < 32'(NUM_VEC));
  assign pbaOk    = (32'(pbaRaw) < 32'(PBA_WORDS));

  assign tabHit = regValid && (regSpace == SP_TAB) && entryOk &&
                  ((sz32 && sub[1:0] == 2'b00) || (sz64 && sub[2:0] == 3'b000));
  assign pbaHit = regValid && (regSpace == SP_PBA) && pbaOk &&
                  ((sz32 && regAddr[1:0] == 2'b00) || (sz64 && regAddr[2:0] == 3'b000));
  assign ctlHit = regValid && (regSpace == SP_CTL) && (sz32 || sz64) && (regAddr == '0);
  assign ctlWr  = ctlHit && regWrite;

  assign entryIdx = entryRaw[VW-1:0];
  assign pbaIdx   = pbaRaw[PW-1:0];

  // function-level control bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmaskQ <= 1'b1;
      fenQ   <= 1'b0;
    end else if (ctlWr) begin
      fmaskQ <= ctlBits[0];
      fenQ   <= ctlBits[1];
    end
  end

  assign funcMasked  = fmaskQ;
  assign funcEnabled = fenQ;

  assign evInRange = intReq && (32'(intVec) < 32'(NUM_VEC));
  assign deliver   = fenQ && !fmaskQ && !vecMask[intVec];

  always_comb begin
    stb          = '0;
    stb.wide     = sz64;
    stb.wrLo     = tabHit && regWrite && (sel == 2'd0);
    stb.wrHi     = tabHit && regWrite && ((sel == 2'd1) || (sz64 && sel == 2'd0));
    stb.wrDat    = tabHit && regWrite && (sel == 2'd2);
    stb.wrVc     = tabHit && regWrite && ((sel == 2'd3) || (sz64 && sel == 2'd2));
    stb.rdEn     = regValid && !regWrite;
    stb.rdTab    = tabHit && !regWrite;
    stb.rdPba    = pbaHit && !regWrite;
    stb.rdCtl    = ctlHit && !regWrite;
    stb.rdSel    = (regSpace == SP_PBA) ? {1'b0, regAddr[2]} : sel;
    stb.evSend   = evInRange && deliver;
    stb.evPend   = evInRange && !deliver;
    stb.flushAll = ctlWr && fmaskQ && !ctlBits[0];
  end

  AST_PBA_SPACE_NO_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regSpace == SP_PBA) |-> !(stb.wrLo || stb.wrHi || stb.wrDat || stb.wrVc)); // R7

  AST_MASK_ONLY_BY_CTL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctlWr) |-> ($stable(fmaskQ) && $stable(fenQ))); // R4

endmodule

// File: rtl/msix_dp.sv
module msix_dp
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  localparam int VW        = $clog2(NUM_VEC),
  localparam int PBA_WORDS = NUM_VEC / 64 + 1,
  localparam int PW        = (PBA_WORDS > 1) ? $clog2(PBA_WORDS) : 1,
  localparam int PBA_BITS  = PBA_WORDS * 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [VW-1:0]      entryIdx,
  input  logic [PW-1:0]      pbaIdx,
  input  logic [63:0]        wdata,
  input  logic [VW-1:0]      evVec,
  input  logic               funcMasked,
  input  logic               funcEnabled,
  output logic [NUM_VEC-1:0] vecMask,
  output logic               rvalid,
  output logic [63:0]        rdata,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData
);

  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] msgDat [NUM_VEC];
  logic [31:0] vecCtl [NUM_VEC];

  logic [NUM_VEC-1:0] pendQ, sendQ;
  logic [NUM_VEC-1:0] evBit, entBit, pendSet, sendSet, pendCand, xfer, clrBit;
  logic [31:0]        hiVal, vcVal;
  logic               vecUnmask;
  logic [VW-1:0]      pick;
  logic               found, launch;
  logic [PBA_BITS-1:0] pbaFlat;
  logic [63:0]        pbaWord, rdNext;

  assign hiVal = stb.wide ? wdata[63:32] : wdata[31:0];
  assign vcVal = stb.wide ? wdata[63:32] : wdata[31:0];

  for (genvar g = 0; g < NUM_VEC; g++) begin : gMask
    assign vecMask[g] = vecCtl[g][0];
  end

  // table storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        addrLo[i] <= '0;
        addrHi[i] <= '0;
        msgDat[i] <= '0;
        vecCtl[i] <= 32'h1;
      end
    end else begin
      if (stb.wrLo)  addrLo[entryIdx] <= wdata[31:0];
      if (stb.wrHi)  addrHi[entryIdx] <= hiVal;
      if (stb.wrDat) msgDat[entryIdx] <= wdata[31:0];
      if (stb.wrVc)  vecCtl[entryIdx] <= vcVal;
    end
  end

  // pending and release bookkeeping
  assign evBit     = NUM_VEC'(1) << evVec;
  assign entBit    = NUM_VEC'(1) << entryIdx;
  assign pendSet   = stb.evPend ? evBit : '0;
  assign sendSet   = stb.evSend ? evBit : '0;
  assign pendCand  = pendQ | pendSet;
  assign vecUnmask = stb.wrVc && vecCtl[entryIdx][0] && !vcVal[0] && !funcMasked;

  always_comb begin
    xfer = '0;
    if (stb.flushAll)   xfer = pendCand & ~vecMask;
    else if (vecUnmask) xfer = pendCand & entBit;
  end

  // lowest pending release wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (sendQ[i]) begin
        pick  = VW'(i);
        found = 1'b1;
      end
    end
  end

  assign launch = found && (!msgValid || msgReady);
  assign clrBit = launch ? (NUM_VEC'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      sendQ <= '0;
    end else begin
      pendQ <= pendCand & ~xfer;
      sendQ <= (sendQ & ~clrBit) | sendSet | xfer;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else if (launch) begin
      msgValid <= 1'b1;
      msgAddr  <= {addrHi[pick], addrLo[pick]};
      msgData  <= msgDat[pick];
    end else if (msgReady) begin
      msgValid <= 1'b0;
    end
  end

  // read path
  assign pbaFlat = {{(PBA_BITS - NUM_VEC){1'b0}}, pendQ};
  assign pbaWord = pbaFlat[{pbaIdx, 6'b0} +: 64];

  always_comb begin
    rdNext = '0;
    if (stb.rdTab) begin
      if (stb.wide) begin
        rdNext = stb.rdSel[1] ? {vecCtl[entryIdx], msgDat[entryIdx]}
                              : {addrHi[entryIdx], addrLo[entryIdx]};
      end else begin
        case (stb.rdSel)
          2'd0:    rdNext = {32'b0, addrLo[entryIdx]};
          2'd1:    rdNext = {32'b0, addrHi[entryIdx]};
          2'd2:    rdNext = {32'b0, msgDat[entryIdx]};
          default: rdNext = {32'b0, vecCtl[entryIdx]};
        endcase
      end
    end else if (stb.rdPba) begin
      if (stb.wide)          rdNext = pbaWord;
      else if (stb.rdSel[0]) rdNext = {32'b0, pbaWord[63:32]};
      else                   rdNext = {32'b0, pbaWord[31:0]};
    end else if (stb.rdCtl) begin
      rdNext = {48'b0, funcEnabled, funcMasked, 3'b0, 11'(NUM_VEC - 1)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= stb.rdEn;
      rdata  <= rdNext;
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData))); // R5

  AST_MSG_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(|sendQ)); // R5

  AST_PEND_FROM_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendQ & ~$past(pendQ))) |-> $past(stb.evPend)); // R6

  AST_ONE_RELEASE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones($past(sendQ) & ~sendQ) <= 1); // R9

  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.flushAll |=> ((pendQ & ~vecMask) == '0)); // R9

endmodule

// File: rtl/msix_vector_ctl.sv
module msix_vector_ctl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 16,
  localparam int VW        = $clog2(NUM_VEC),
  localparam int PBA_WORDS = NUM_VEC / 64 + 1,
  localparam int PW        = (PBA_WORDS > 1) ? $clog2(PBA_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regSpace,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regSize,
  input  logic [63:0]       regWdata,
  output logic              regRvalid,
  output logic [63:0]       regRdata,
  input  logic              intReq,
  input  logic [VW-1:0]     intVec,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [63:0]       msgAddr,
  output logic [31:0]       msgData
);

  dpStrobe_t          stb;
  logic [VW-1:0]      entryIdx;
  logic [PW-1:0]      pbaIdx;
  logic               funcMasked, funcEnabled;
  logic [NUM_VEC-1:0] vecMask;

  msix_ctrl #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regValid   (regValid),
    .regWrite   (regWrite),
    .regSpace   (regSpace),
    .regAddr    (regAddr),
    .regSize    (regSize),
    .ctlBits    (regWdata[15:14]),
    .intReq     (intReq),
    .intVec     (intVec),
    .vecMask    (vecMask),
    .stb        (stb),
    .entryIdx   (entryIdx),
    .pbaIdx     (pbaIdx),
    .funcMasked (funcMasked),
    .funcEnabled(funcEnabled)
  );

  msix_dp #(.NUM_VEC(NUM_VEC)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .entryIdx   (entryIdx),
    .pbaIdx     (pbaIdx),
    .wdata      (regWdata),
    .evVec      (intVec),
    .funcMasked (funcMasked),
    .funcEnabled(funcEnabled),
    .vecMask    (vecMask),
    .rvalid     (regRvalid),
    .rdata      (regRdata),
    .msgValid   (msgValid),
    .msgReady   (msgReady),
    .msgAddr    (msgAddr),
    .msgData    (msgData)
  );

endmodule

// File: tb/tb_msix_vector_ctl.sv
module tb_msix_vector_ctl;

  localparam int N      = 70;
  localparam int ADDR_W = 16;
  localparam int VW     = $clog2(N);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regValid = 1'b0, regWrite = 1'b0;
  logic [1:0]        regSpace = '0, regSize = '0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [63:0]       regWdata = '0;
  logic              regRvalid;
  logic [63:0]       regRdata;
  logic              intReq = 1'b0;
  logic [VW-1:0]     intVec = '0;
  logic              msgValid, msgReady = 1'b1;
  logic [63:0]       msgAddr;
  logic [31:0]       msgData;

  int nChk = 0, nFail = 0, mCnt = 0;
  logic [63:0] mAddr [0:63];
  logic [31:0] mData [0:63];

  always #5 clk = ~clk;

  msix_vector_ctl #(.NUM_VEC(N), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regSpace(regSpace), .regAddr(regAddr), .regSize(regSize), .regWdata(regWdata),
    .regRvalid(regRvalid), .regRdata(regRdata), .intReq(intReq), .intVec(intVec),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  always @(posedge clk) begin
    if (rstN && msgValid && msgReady) begin
      if (mCnt < 64) begin
        mAddr[mCnt] = msgAddr;
        mData[mCnt] = msgData;
      end
      mCnt = mCnt + 1;
    end
  end

  function automatic logic [31:0] loOf(int v);  return 32'h1000_0000 + 32'(v * 16); endfunction
  function automatic logic [31:0] hiOf(int v);  return 32'hA000_0000 + 32'(v);      endfunction
  function automatic logic [31:0] datOf(int v); return 32'hD000_0000 + 32'(v);      endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(logic [1:0] sp, int addr, logic [1:0] sz, logic [63:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regSpace = sp;
    regAddr = ADDR_W'(addr); regSize = sz; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(logic [1:0] sp, int addr, logic [1:0] sz, output logic [63:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regSpace = sp;
    regAddr = ADDR_W'(addr); regSize = sz;
    @(negedge clk);
    regValid = 1'b0;
    d = regRvalid ? regRdata : 64'hBAD0_BAD0_BAD0_BAD0;
  endtask

  task automatic rdChk(string tag, logic [1:0] sp, int addr, logic [1:0] sz, logic [63:0] exp);
    logic [63:0] d;
    regRd(sp, addr, sz, d);
    chk(tag, d, exp);
  endtask

  task automatic fire(int v);
    @(negedge clk);
    intReq = 1'b1; intVec = VW'(v);
    @(negedge clk);
    intReq = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic msgChk(string tag, int idx, int v);
    chk(tag, mAddr[idx], {hiOf(v), loOf(v)});
    chk(tag, {32'b0, mData[idx]}, {32'b0, datOf(v)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk("R1 ctl reset", 2'd0, 0, 2'd2, 64'h4000 | 64'(N - 1));
    for (int v = 0; v < N; v++) begin
      rdChk("R1 R3 entry addr reset", 2'd1, v * 16, 2'd3, 64'h0);
      rdChk("R1 R3 entry ctl/data reset", 2'd1, v * 16 + 8, 2'd3, {32'h1, 32'h0});
    end
    rdChk("R1 pba word0 reset", 2'd2, 0, 2'd3, 64'h0);
    rdChk("R1 pba word1 reset", 2'd2, 8, 2'd3, 64'h0);

    // R2 R3 program every entry, alternating access widths
    for (int v = 0; v < N; v++) begin
      if (v % 2 == 0) begin
        regWr(2'd1, v * 16,      2'd2, {32'b0, loOf(v)});
        regWr(2'd1, v * 16 + 4,  2'd2, {32'b0, hiOf(v)});
        regWr(2'd1, v * 16 + 8,  2'd2, {32'b0, datOf(v)});
        regWr(2'd1, v * 16 + 12, 2'd2, 64'h1);
      end else begin
        regWr(2'd1, v * 16,     2'd3, {hiOf(v), loOf(v)});
        regWr(2'd1, v * 16 + 8, 2'd3, {32'h1, datOf(v)});
      end
    end
    for (int v = 0; v < N; v++) begin
      rdChk("R3 wide addr readback", 2'd1, v * 16, 2'd3, {hiOf(v), loOf(v)});
      rdChk("R2 narrow hi readback", 2'd1, v * 16 + 4, 2'd2, {32'b0, hiOf(v)});
      rdChk("R2 narrow data readback", 2'd1, v * 16 + 8, 2'd2, {32'b0, datOf(v)});
      rdChk("R2 narrow vctl readback", 2'd1, v * 16 + 12, 2'd2, 64'h1);
    end

    // R4 control word
    regWr(2'd0, 0, 2'd2, 64'hFFFF);
    rdChk("R4 ctl all ones write", 2'd0, 0, 2'd2, 64'hC000 | 64'(N - 1));
    regWr(2'd0, 0, 2'd2, 64'h8000);
    rdChk("R4 ctl enabled unmasked", 2'd0, 0, 2'd3, 64'h8000 | 64'(N - 1));
    settle();
    chk("R9 unmask with nothing pending", 64'(mCnt), 64'd0);

    // R5 direct delivery with backpressure
    regWr(2'd1, 3 * 16 + 12, 2'd2, 64'h0);
    msgReady = 1'b0;
    fire(3);
    repeat (4) @(negedge clk);
    chk("R5 valid under backpressure", {63'b0, msgValid}, 64'd1);
    chk("R5 addr under backpressure", msgAddr, {hiOf(3), loOf(3)});
    repeat (3) @(negedge clk);
    chk("R5 addr still held", msgAddr, {hiOf(3), loOf(3)});
    chk("R5 data still held", {32'b0, msgData}, {32'b0, datOf(3)});
    msgReady = 1'b1;
    settle();
    chk("R5 one message", 64'(mCnt), 64'd1);
    msgChk("R5 message content", 0, 3);
    chk("R5 valid drops", {63'b0, msgValid}, 64'd0);

    // R6 R7 masked vectors become pending
    fire(5); fire(66); fire(40);
    settle();
    chk("R6 no message for masked", 64'(mCnt), 64'd1);
    rdChk("R7 pba w0 low", 2'd2, 0, 2'd2, 64'h20);
    rdChk("R7 pba w0 high", 2'd2, 4, 2'd2, 64'h100);
    rdChk("R7 pba w0 wide", 2'd2, 0, 2'd3, 64'h0000_0100_0000_0020);
    rdChk("R7 pba w1 low", 2'd2, 8, 2'd2, 64'h4);
    rdChk("R7 pba w1 wide", 2'd2, 8, 2'd3, 64'h4);
    regWr(2'd2, 0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    regWr(2'd2, 8, 2'd2, 64'h0);
    rdChk("R7 pba write ignored w0", 2'd2, 0, 2'd3, 64'h0000_0100_0000_0020);
    rdChk("R7 pba write ignored w1", 2'd2, 8, 2'd3, 64'h4);

    // R8 vector unmask releases its pending bit
    regWr(2'd1, 5 * 16 + 12, 2'd2, 64'h0);
    settle();
    chk("R8 one release", 64'(mCnt), 64'd2);
    msgChk("R8 release content", 1, 5);
    rdChk("R8 pending cleared", 2'd2, 0, 2'd2, 64'h0);

    // R8 with the function masked nothing is released
    regWr(2'd0, 0, 2'd2, 64'hC000);
    fire(3);
    regWr(2'd1, 40 * 16 + 8, 2'd3, {32'h0, datOf(40)});
    fire(10);
    settle();
    chk("R8 no release under function mask", 64'(mCnt), 64'd2);
    rdChk("R8 bit 40 still pending", 2'd2, 4, 2'd2, 64'h100);
    rdChk("R6 bits 3 and 10 pending", 2'd2, 0, 2'd2, 64'h408);

    // R9 function unmask drains in ascending order
    regWr(2'd0, 0, 2'd2, 64'h8000);
    settle();
    chk("R9 two releases", 64'(mCnt), 64'd4);
    msgChk("R9 first is vector 3", 2, 3);
    msgChk("R9 second is vector 40", 3, 40);
    rdChk("R9 masked 10 kept", 2'd2, 0, 2'd2, 64'h400);
    rdChk("R9 bit 40 cleared", 2'd2, 4, 2'd2, 64'h0);
    rdChk("R9 masked 66 kept", 2'd2, 8, 2'd2, 64'h4);

    // R10 reserved accesses
    rdChk("R10 unaligned narrow", 2'd1, 16 + 2, 2'd2, 64'h0);
    rdChk("R10 misplaced wide", 2'd1, 16 + 4, 2'd3, 64'h0);
    rdChk("R10 bad size", 2'd1, 16, 2'd1, 64'h0);
    rdChk("R10 entry beyond table", 2'd1, N * 16 + 8, 2'd2, 64'h0);
    rdChk("R10 unused space", 2'd3, 0, 2'd2, 64'h0);
    rdChk("R10 pba word beyond array", 2'd2, 16, 2'd2, 64'h0);
    rdChk("R10 pba misplaced wide", 2'd2, 4, 2'd3, 64'h0);
    rdChk("R10 ctl nonzero offset", 2'd0, 4, 2'd2, 64'h0);
    regWr(2'd1, 16 + 4, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    regWr(2'd1, 32, 2'd1, 64'hFFFF_FFFF);
    regWr(2'd1, N * 16, 2'd2, 64'hFFFF_FFFF);
    regWr(2'd0, 2, 2'd2, 64'h4000);
    rdChk("R10 entry1 addr untouched", 2'd1, 16, 2'd3, {hiOf(1), loOf(1)});
    rdChk("R10 entry1 ctl untouched", 2'd1, 24, 2'd3, {32'h1, datOf(1)});
    rdChk("R10 entry2 low untouched", 2'd1, 32, 2'd2, {32'b0, loOf(2)});
    rdChk("R10 ctl untouched", 2'd0, 0, 2'd2, 64'h8000 | 64'(N - 1));

    // R11 event together with the vector-unmask write
    base = mCnt;
    @(negedge clk);
    intReq = 1'b1; intVec = VW'(12);
    regValid = 1'b1; regWrite = 1'b1; regSpace = 2'd1;
    regAddr = ADDR_W'(12 * 16 + 12); regSize = 2'd2; regWdata = 64'h0;
    @(negedge clk);
    intReq = 1'b0; regValid = 1'b0; regWrite = 1'b0;
    settle();
    chk("R11 vector collision one message", 64'(mCnt - base), 64'd1);
    msgChk("R11 vector collision content", base, 12);
    rdChk("R11 vector collision no pending", 2'd2, 0, 2'd2, 64'h400);

    // R11 event together with the function-unmask write
    regWr(2'd0, 0, 2'd2, 64'hC000);
    regWr(2'd1, 20 * 16 + 12, 2'd2, 64'h0);
    base = mCnt;
    @(negedge clk);
    intReq = 1'b1; intVec = VW'(20);
    regValid = 1'b1; regWrite = 1'b1; regSpace = 2'd0;
    regAddr = '0; regSize = 2'd2; regWdata = 64'h8000;
    @(negedge clk);
    intReq = 1'b0; regValid = 1'b0; regWrite = 1'b0;
    settle();
    chk("R11 function collision one message", 64'(mCnt - base), 64'd1);
    msgChk("R11 function collision content", base, 20);
    rdChk("R11 function collision no pending", 2'd2, 0, 2'd2, 64'h400);

    // R6 disabled function parks an unmasked vector; R9 enable alone releases nothing
    regWr(2'd0, 0, 2'd2, 64'h0);
    base = mCnt;
    fire(3);
    settle();
    chk("R6 disabled no message", 64'(mCnt - base), 64'd0);
    rdChk("R6 disabled sets pending", 2'd2, 0, 2'd2, 64'h408);
    regWr(2'd0, 0, 2'd2, 64'h8000);
    settle();
    chk("R9 enable without mask edge", 64'(mCnt - base), 64'd0);
    rdChk("R9 pending kept after enable", 2'd2, 0, 2'd2, 64'h408);

    summary();
  end

endmodule